// File: doc/BRIEF.md
# Lane-Masked Integer Compare Array

This block is the compare stage of a 64-lane vector unit. For every lane it compares two integer operands taken from wide per-lane operand buses and collects the single-bit outcomes into a lane mask. Bit n of that mask always holds the result of lane n. A lane that is switched off in the incoming execution mask always yields a zero bit, whatever its operands.

An 8-bit opcode selects the work to do. Its top bit must be set and bit 3 must be clear. The three low bits select the predicate. Bit 5 selects 64-bit or 32-bit operands, and bit 6 selects unsigned or signed interpretation. Bit 4 marks the variants whose result also replaces the execution mask. Every other opcode is refused: the block raises an illegal-opcode pulse and changes no output register. A strobed request produces its result one clock later, together with a one-cycle valid pulse. The destination mask and the execution-mask output hold their values between results.

Top module: `lane_cmp_array`

## Requirements
- R1: While reset is asserted and directly after it is released, `res_valid`, `exec_wr_en` and `bad_op` are 0 and `dst_mask` and `exec_new` are all zeros.
- R2: A strobe with a legal opcode gives `res_valid` high for exactly the one cycle after the strobe edge. With no strobe, no pulse appears and `dst_mask` keeps its value.
- R3: The predicate is `op_code[2:0]`: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. "Never" gives an all-zero mask and "always" gives a mask equal to the execution mask.
- R4: Codes 0x80–0x87 and 0x90–0x97 compare bits [31:0] of each operand as signed two's-complement values. Bits [63:32] of the operands have no effect.
- R5: Codes 0xA0–0xA7 and 0xB0–0xB7 compare the full 64-bit operands as signed values.
- R6: Codes 0xC0–0xC7 and 0xD0–0xD7 compare bits [31:0] as unsigned values. Codes 0xE0–0xE7 and 0xF0–0xF7 compare all 64 bits as unsigned values.
- R7: Bit n of `dst_mask` holds the result of lane n, whose operands are bits [64n+63:64n] of `src_a` and `src_b`.
- R8: A lane whose bit in `exec_in` is 0 at the strobe gives a 0 in `dst_mask`.
- R9: For legal codes with bit 4 set, `exec_wr_en` pulses together with `res_valid`, and `exec_new` takes the same value as `dst_mask`. For legal codes with bit 4 clear, `exec_wr_en` stays 0 and `exec_new` keeps its value.
- R10: A strobed code with bit 7 clear or bit 3 set gives a one-cycle `bad_op` pulse one clock later. In that case there is no `res_valid` or `exec_wr_en` pulse, and `dst_mask` and `exec_new` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per compare |
| op_code | input | 8 | Compare opcode |
| exec_in | input | LANES (64) | Current execution mask, one bit per lane |
| src_a | input | LANES*WORD_W (4096) | First operand of each lane, lane n at bits [64n+63:64n] |
| src_b | input | LANES*WORD_W (4096) | Second operand of each lane, same layout |
| res_valid | output | 1 | One-cycle pulse: a new destination mask is present |
| dst_mask | output | LANES (64) | Registered compare result mask |
| exec_new | output | LANES (64) | Registered replacement execution mask |
| exec_wr_en | output | 1 | One-cycle pulse: `exec_new` was just loaded |
| bad_op | output | 1 | One-cycle pulse: the last strobe carried an illegal opcode |

## Verification
A wrong decode of the type bits shows up as a mask mismatch one clock after the strobe. Only operands that straddle the sign boundary or differ only in their upper half expose it, so the operand corners are chosen to land there. A faulty execution-write path leaves `exec_new` stale or loaded when it should not be. This is visible on the very next result, and it is also caught by comparing `exec_new` with `dst_mask` on every pulse. A broken hold path under illegal codes changes the registered masks in the cycle after the refused strobe.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;

  typedef enum logic [2:0] {
    PR_NEVER  = 3'd0,
    PR_LESS   = 3'd1,
    PR_EQUAL  = 3'd2,
    PR_LEQ    = 3'd3,
    PR_GREAT  = 3'd4,
    PR_NEQ    = 3'd5,
    PR_GEQ    = 3'd6,
    PR_ALWAYS = 3'd7
  } pred_e;

  typedef struct packed {
    logic  legal;
    logic  exec_wr;
    logic  wide;
    logic  is_unsigned;
    pred_e pred;
  } cmp_ctl_t;

endpackage

// File: rtl/lane_cmp_decode.sv
module lane_cmp_decode
  import lane_cmp_pkg::*;
(
  input  logic [7:0] op_code,
  output cmp_ctl_t   ctl
);

  // Opcode layout: [7] must be 1, [6] unsigned, [5] 64-bit,
  // [4] also write execution mask, [3] must be 0, [2:0] predicate.
  always_comb begin
    ctl.legal       = op_code[7] & ~op_code[3];
    ctl.is_unsigned = op_code[6];
    ctl.wide        = op_code[5];
    ctl.exec_wr     = op_code[4];
    ctl.pred        = pred_e'(op_code[2:0]);
  end

endmodule

// File: rtl/lane_cmp_unit.sv
module lane_cmp_unit
  import lane_cmp_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  cmp_ctl_t          ctl,
  input  logic              active,
  output logic              hit
);

  localparam int HALF_W = WORD_W / 2;
  localparam int EXT_W  = WORD_W + 1;
  localparam int PAD_W  = EXT_W - HALF_W;

  logic [EXT_W-1:0] a_x;
  logic [EXT_W-1:0] b_x;
  logic             lt;
  logic             eq;
  logic             raw;

  // Extend to one extra bit so one signed compare serves all four types.
  always_comb begin
    if (ctl.wide) begin
      a_x = {~ctl.is_unsigned & opa[WORD_W-1], opa};
      b_x = {~ctl.is_unsigned & opb[WORD_W-1], opb};
    end else begin
      a_x = {{PAD_W{~ctl.is_unsigned & opa[HALF_W-1]}}, opa[HALF_W-1:0]};
      b_x = {{PAD_W{~ctl.is_unsigned & opb[HALF_W-1]}}, opb[HALF_W-1:0]};
    end
  end

  assign lt = $signed(a_x) < $signed(b_x);
  assign eq = (a_x == b_x);

  always_comb begin
    unique case (ctl.pred)
      PR_NEVER:  raw = 1'b0;
      PR_LESS:   raw = lt;
      PR_EQUAL:  raw = eq;
      PR_LEQ:    raw = lt | eq;
      PR_GREAT:  raw = ~lt & ~eq;
      PR_NEQ:    raw = ~eq;
      PR_GEQ:    raw = ~lt;
      PR_ALWAYS: raw = 1'b1;
      default:   raw = 1'b0;
    endcase
  end

  assign hit = active & raw;

endmodule

// File: rtl/lane_cmp_result_reg.sv
module lane_cmp_result_reg
  import lane_cmp_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  cmp_ctl_t         ctl,
  input  logic [LANES-1:0] hits,
  output logic             res_valid,
  output logic [LANES-1:0] dst_mask,
  output logic [LANES-1:0] exec_new,
  output logic             exec_wr_en,
  output logic             bad_op
);

  logic [LANES-1:0] dst_q, dst_d;
  logic [LANES-1:0] exe_q, exe_d;
  logic             vld_q, vld_d;
  logic             we_q,  we_d;
  logic             ill_q, ill_d;
  logic             dst_en;
  logic             exe_en;

  assign dst_en = req_valid & ctl.legal;
  assign exe_en = dst_en & ctl.exec_wr;

  always_comb begin
    dst_d = dst_q;
    exe_d = exe_q;
    if (dst_en) dst_d = hits;
    if (exe_en) exe_d = hits;
    vld_d = dst_en;
    we_d  = exe_en;
    ill_d = req_valid & ~ctl.legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      exe_q <= '0;
      vld_q <= 1'b0;
      we_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      dst_q <= dst_d;
      exe_q <= exe_d;
      vld_q <= vld_d;
      we_q  <= we_d;
      ill_q <= ill_d;
    end
  end

  assign res_valid  = vld_q;
  assign dst_mask   = dst_q;
  assign exec_new   = exe_q;
  assign exec_wr_en = we_q;
  assign bad_op     = ill_q;

  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vld_q, ill_q}));

  p_exec_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (exe_q == dst_q));

  p_we_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> vld_q);

  p_exec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> $stable(exe_q));

  p_illegal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> ($stable(dst_q) && $stable(exe_q)));

  p_dst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(dst_q));

endmodule

// File: rtl/lane_cmp_array.sv
module lane_cmp_array
  import lane_cmp_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int WORD_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [7:0]              op_code,
  input  logic [LANES-1:0]        exec_in,
  input  logic [LANES*WORD_W-1:0] src_a,
  input  logic [LANES*WORD_W-1:0] src_b,
  output logic                    res_valid,
  output logic [LANES-1:0]        dst_mask,
  output logic [LANES-1:0]        exec_new,
  output logic                    exec_wr_en,
  output logic                    bad_op
);

  cmp_ctl_t         ctl;
  logic [LANES-1:0] hits;

  lane_cmp_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_cmp_unit #(.WORD_W(WORD_W)) u_unit (
      .opa    (src_a[g*WORD_W +: WORD_W]),
      .opb    (src_b[g*WORD_W +: WORD_W]),
      .ctl    (ctl),
      .active (exec_in[g]),
      .hit    (hits[g])
    );
  end

  lane_cmp_result_reg #(.LANES(LANES)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ctl        (ctl),
    .hits       (hits),
    .res_valid  (res_valid),
    .dst_mask   (dst_mask),
    .exec_new   (exec_new),
    .exec_wr_en (exec_wr_en),
    .bad_op     (bad_op)
  );

  p_result_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid));

  p_inactive_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((dst_mask & ~$past(exec_in)) == '0));

  p_illegal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> (!$past(op_code[7]) || $past(op_code[3])));

  p_always_pred_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(op_code[2:0]) == 3'd7)) |-> (dst_mask == $past(exec_in)));

  p_never_pred_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(op_code[2:0]) == 3'd0)) |-> (dst_mask == '0));

endmodule

// File: tb/tb_lane_cmp_array.sv
`timescale 1ns/1ps
module tb_lane_cmp_array;

  localparam int LN = 8;
  localparam int WW = 64;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [7:0]        op_code;
  logic [LN-1:0]     exec_in;
  logic [LN*WW-1:0]  src_a;
  logic [LN*WW-1:0]  src_b;
  logic              res_valid;
  logic [LN-1:0]     dst_mask;
  logic [LN-1:0]     exec_new;
  logic              exec_wr_en;
  logic              bad_op;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [LN-1:0] m_dst;
  logic [LN-1:0] m_exe;

  lane_cmp_array #(.LANES(LN), .WORD_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_code(op_code),
    .exec_in(exec_in), .src_a(src_a), .src_b(src_b), .res_valid(res_valid),
    .dst_mask(dst_mask), .exec_new(exec_new), .exec_wr_en(exec_wr_en),
    .bad_op(bad_op)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] corner(int i);
    case (i % 10)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h0000_0000_7FFF_FFFF;
      4: return 64'h0000_0000_8000_0000;
      5: return 64'hFFFF_FFFF_0000_0000;
      6: return 64'h8000_0000_0000_0000;
      7: return 64'h7FFF_FFFF_FFFF_FFFF;
      8: return 64'h1234_5678_0000_0001;
      default: return 64'hFFFF_FFFF_8000_0000;
    endcase
  endfunction

  function automatic logic model(logic [7:0] op, logic [63:0] a, logic [63:0] b);
    logic lt, eq;
    logic [31:0] al, bl;
    al = a[31:0];
    bl = b[31:0];
    case (op[6:5])
      2'b00: begin lt = $signed(al) < $signed(bl); eq = (al == bl); end
      2'b01: begin lt = $signed(a) < $signed(b);   eq = (a == b);   end
      2'b10: begin lt = al < bl;                   eq = (al == bl); end
      default: begin lt = a < b;                   eq = (a == b);   end
    endcase
    case (op[2:0])
      3'd0: return 1'b0;
      3'd1: return lt;
      3'd2: return eq;
      3'd3: return lt | eq;
      3'd4: return !(lt | eq);
      3'd5: return !eq;
      3'd6: return !lt;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string type_tag(logic [7:0] op);
    if (op[2:0] == 3'd0 || op[2:0] == 3'd7) return "R3 fixed-predicate";
    case (op[6:5])
      2'b00: return "R4 signed32";
      2'b01: return "R5 signed64";
      default: return "R6 unsigned";
    endcase
  endfunction

  task automatic apply(logic [7:0] op, logic [LN-1:0] em,
                       logic [LN*WW-1:0] a, logic [LN*WW-1:0] b);
    logic [LN-1:0] exp;
    logic legal;
    legal = op[7] & ~op[3];
    for (int l = 0; l < LN; l++)
      exp[l] = em[l] & model(op, a[l*WW +: WW], b[l*WW +: WW]);
    @(negedge clk);
    op_code = op; exec_in = em; src_a = a; src_b = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (legal) begin
      m_dst = exp;
      if (op[4]) m_exe = exp;
      chk("R2 res_valid pulse", 64'(res_valid), 64'd1);
      chk(type_tag(op), 64'(dst_mask), 64'(m_dst));
      chk("R8 inactive lanes zero", 64'(dst_mask & ~em), 64'd0);
      chk("R9 exec_wr_en", 64'(exec_wr_en), 64'(op[4]));
      chk("R9 exec_new", 64'(exec_new), 64'(m_exe));
      chk("R10 no bad_op on legal", 64'(bad_op), 64'd0);
    end else begin
      chk("R10 bad_op pulse", 64'(bad_op), 64'd1);
      chk("R10 no res_valid", 64'(res_valid), 64'd0);
      chk("R10 no exec_wr_en", 64'(exec_wr_en), 64'd0);
      chk("R10 dst_mask unchanged", 64'(dst_mask), 64'(m_dst));
      chk("R10 exec_new unchanged", 64'(exec_new), 64'(m_exe));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [LN*WW-1:0] a, b;
    logic [LN-1:0] em;
    rst_n = 1'b0; req_valid = 1'b0; op_code = 8'h0; exec_in = '0;
    src_a = '0; src_b = '0;
    m_dst = '0; m_exe = '0;
    repeat (3) @(negedge clk);
    chk("R1 res_valid in reset", 64'(res_valid), 64'd0);
    chk("R1 dst_mask in reset", 64'(dst_mask), 64'd0);
    chk("R1 exec_new in reset", 64'(exec_new), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 exec_wr_en after reset", 64'(exec_wr_en), 64'd0);
    chk("R1 bad_op after reset", 64'(bad_op), 64'd0);
    chk("R1 dst_mask after reset", 64'(dst_mask), 64'd0);
    repeat (3) @(negedge clk);
    chk("R2 no pulse when idle", 64'(res_valid), 64'd0);

    // Full opcode sweep over ten operand/mask patterns.
    for (int p = 0; p < 10; p++) begin
      for (int l = 0; l < LN; l++) begin
        a[l*WW +: WW] = corner(p + l);
        b[l*WW +: WW] = corner(p * 3 + l * 7 + 1);
      end
      em = (p == 0) ? 8'hFF : 8'(8'hFF ^ (p * 37));
      for (int op = 0; op < 256; op++) apply(8'(op), em, a, b);
    end

    // R7: one lane differs, so exactly its bit is set for not-equal.
    for (int k = 0; k < LN; k++) begin
      a = '0; b = '0;
      b[k*WW +: WW] = 64'h1;
      apply(8'h85, 8'hFF, a, b);
      chk("R7 lane position", 64'(dst_mask), 64'(1) << k);
    end

    // R4: upper halves differ but low halves match under a 32-bit equal.
    a = '0; b = '0;
    for (int l = 0; l < LN; l++) begin
      a[l*WW +: WW] = 64'hDEAD_0000_0000_0005;
      b[l*WW +: WW] = 64'h0000_BEEF_0000_0005;
    end
    apply(8'h82, 8'hFF, a, b);
    chk("R4 upper bits ignored", 64'(dst_mask), 64'hFF);

    // R2: idle cycles after a result keep the mask and give no pulse.
    repeat (2) @(negedge clk);
    chk("R2 idle no pulse", 64'(res_valid), 64'd0);
    chk("R2 idle mask held", 64'(dst_mask), 64'hFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule